// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register bank of a clock control unit. It sits on a simple 32-bit bus in which every access is a full word and the word is chosen by the byte address shifted right by two. The bank holds a mode register, two post-divider registers, two PLL control registers, three clock-gating registers, a power-management register that software can read but not write, and a constant register that always returns the same value. Each writable register has its own mask of bits that can be written. A write clears every bit outside that mask.

A separate frequency calculator works out the derived clock rates from the mode register, the first post-divider and the main PLL control. The bank drives those three registers out continuously. It sends the calculator a one-cycle recompute strobe after any write that can change a clock rate, and once when reset is released. A write to a gating register does not raise the strobe. An access to an address that holds no register raises a one-cycle error pulse, and so does a write to a read-only word. Read data is registered and arrives on the cycle after the request.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the registers hold these values: mode 0x074B0B7B, post-divider 0 0xFF870B48, post-divider 1 0x49FCFE7F, main PLL 0x04001800, secondary PLL 0x04043001, all three gating registers 0xFFFFFFFF, and power-management 0x80209828. The PLL layout is fraction [9:0], integer [13:10], denominator [25:16] and pre-divide [29:26].
- R2: The word index is req_addr[ADDR_W-1:2], and address bits [1:0] are ignored. Registers sit at these word indices: mode 0, post-divider 0 at 1, post-divider 1 at 2, main PLL 4, secondary PLL 6, gating 8, 9 and 10, constant 18, and power-management 23.
- R3: A write stores wdata AND mask, so bits outside the mask become 0. The masks are: mode 0x3B6FDFFF, post-divider 0 0xFF9F3FFF, and both PLL registers 0xBFFF3FFF. Post-divider 1 and the gating registers take all 32 bits.
- R4: Every write to the mode register sets bit 2 (fast-PLL-mode enable) to 1, whatever the value of wdata[2].
- R5: Word 18 always reads 0x00004040.
- R6: A write to word 18 or word 23 leaves every register unchanged and pulses err_pulse one cycle later.
- R7: A read of an unmapped word returns 0. A write to an unmapped word changes no register. In both cases err_pulse goes high for one cycle, on the cycle after the request.
- R8: A read request with req_valid=1 and req_write=0 gives rsp_valid=1 and the data on rsp_rdata in the following cycle. No other request gives rsp_valid.
- R9: A write to word 0, 1, 2, 4 or 6 makes recalc_pulse high in the following cycle. A second such write on the next cycle gives a second pulse.
- R10: A write to a gating word, a read-only word or an unmapped word does not raise recalc_pulse, and neither does a read.
- R11: recalc_pulse is high for exactly one cycle, the cycle after the first clock edge following reset release.
- R12: cfg_mode, cfg_pdiv0 and cfg_mpll always show the current contents of the mode, post-divider 0 and main PLL registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | Unmapped access or write to a read-only word |
| recalc_pulse | output | 1 | Recompute request to the frequency calculator |
| cfg_mode | output | 32 | Mode register contents |
| cfg_pdiv0 | output | 32 | Post-divider 0 contents |
| cfg_mpll | output | 32 | Main PLL control contents |

## Verification
The bench aims at the masked writes. A design that merged new bits with old instead of clearing them would leave bit 26 of the mode register set after a write, and a design that dropped the forced bit would read back 0 in bit 2 of the mode register. Word 18 and word 23 are written with arbitrary data and then read back: a bank that decoded them as writable would return the new data, and one that forgot to flag them would stay silent on err_pulse. The bench writes to gating words, unmapped words and recompute words back to back and also in a long pseudo-random mix. These sequences expose a strobe that fires on the wrong registers, misses the second of two adjacent writes, or is missing after reset. Unmapped words near mapped ones (3, 5, 7, 11, 17, 19, 22, 24) and words far above them catch decoders that compare too few address bits.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int NREG = 10;
   localparam int DW   = 32;

   // slot order: mode, pdiv0, pdiv1, mpll, spll, gate0..2, const, pm
   function automatic int unsigned reg_word(input int i);
      case (i)
         0: return 0;   1: return 1;   2: return 2;
         3: return 4;   4: return 6;   5: return 8;
         6: return 9;   7: return 10;  8: return 18;
         default: return 23;
      endcase
   endfunction

   function automatic logic [DW-1:0] reg_rst(input int i);
      case (i)
         0: return 32'h074B0B7B;
         1: return 32'hFF870B48;
         2: return 32'h49FCFE7F;
         3: return 32'h04001800;
         4: return 32'h04043001;
         8: return 32'h00004040;
         9: return 32'h80209828;
         default: return 32'hFFFFFFFF;
      endcase
   endfunction

   function automatic logic [DW-1:0] reg_mask(input int i);
      case (i)
         0: return 32'h3B6FDFFF;
         1: return 32'hFF9F3FFF;
         3, 4: return 32'hBFFF3FFF;
         8, 9: return 32'h0;
         default: return 32'hFFFFFFFF;
      endcase
   endfunction

   function automatic logic [DW-1:0] reg_force(input int i);
      return (i == 0) ? 32'h00000004 : 32'h0;
   endfunction

   function automatic bit reg_writable(input int i);
      return i < 8;
   endfunction

   function automatic bit reg_recalc(input int i);
      return i < 5;
   endfunction

   function automatic logic [NREG-1:0] writable_vec();
      logic [NREG-1:0] v;
      for (int i = 0; i < NREG; i++) v[i] = reg_writable(i);
      return v;
   endfunction

   function automatic logic [NREG-1:0] recalc_vec();
      logic [NREG-1:0] v;
      for (int i = 0; i < NREG; i++) v[i] = reg_recalc(i);
      return v;
   endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
   parameter int WIDX = 10,
   parameter int NREG = clkctl_pkg::NREG
) (
   input  logic [WIDX-1:0] word_idx,
   output logic [NREG-1:0] sel
);
   for (genvar i = 0; i < NREG; i++) begin : g_cmp
      localparam int unsigned WORD = clkctl_pkg::reg_word(i);
      assign sel[i] = (word_idx == WIDX'(WORD));
   end
endmodule

// File: rtl/clkctl_regcell.sv
module clkctl_regcell #(
   parameter int          DW       = 32,
   parameter logic [DW-1:0] RST    = '0,
   parameter logic [DW-1:0] MASK   = '1,
   parameter logic [DW-1:0] FORCE  = '0,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   if (WRITABLE) begin : g_rw
      logic [DW-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q_r <= RST;
         else if (we) q_r <= (wdata & MASK) | FORCE;
      end
      assign q = q_r;
   end else begin : g_ro
      logic unused_ro;
      assign unused_ro = ^{clk, rst_n, we, wdata};
      assign q = RST;
   end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              err_pulse,
   output logic              recalc_pulse,
   output logic [31:0]       cfg_mode,
   output logic [31:0]       cfg_pdiv0,
   output logic [31:0]       cfg_mpll
);
   import clkctl_pkg::*;

   localparam int WIDX = ADDR_W - 2;
   localparam logic [NREG-1:0] WR_VEC = writable_vec();
   localparam logic [NREG-1:0] RC_VEC = recalc_vec();

   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("ADDR_W must reach word index 23");
   end

   logic [WIDX-1:0] word_idx;
   logic [NREG-1:0] sel;
   logic [DW-1:0]   regq [NREG];
   logic [DW-1:0]   rd_terms [NREG];
   logic [DW-1:0]   rd_mux;
   logic            hit, wr_req, rd_req, init_q;
   logic            unused_lo;

   assign word_idx  = req_addr[ADDR_W-1:2];
   assign unused_lo = ^req_addr[1:0];
   assign wr_req    = req_valid & req_write;
   assign rd_req    = req_valid & ~req_write;
   assign hit       = |sel;

   clkctl_decode #(.WIDX(WIDX), .NREG(NREG)) u_dec (
      .word_idx (word_idx),
      .sel      (sel)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      clkctl_regcell #(
         .DW       (DW),
         .RST      (reg_rst(i)),
         .MASK     (reg_mask(i)),
         .FORCE    (reg_force(i)),
         .WRITABLE (reg_writable(i))
      ) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_req & sel[i]),
         .wdata (req_wdata),
         .q     (regq[i])
      );
      if (i == 0) begin : g_first
         assign rd_terms[i] = regq[i] & {DW{sel[i]}};
      end else begin : g_rest
         assign rd_terms[i] = rd_terms[i-1] | (regq[i] & {DW{sel[i]}});
      end
   end

   assign rd_mux = rd_terms[NREG-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q       <= 1'b1;
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         err_pulse    <= 1'b0;
         recalc_pulse <= 1'b0;
      end else begin
         init_q       <= 1'b0;
         rsp_valid    <= rd_req;
         if (rd_req) rsp_rdata <= rd_mux;
         err_pulse    <= req_valid & (~hit | (req_write & ~|(sel & WR_VEC)));
         recalc_pulse <= init_q | (wr_req & |(sel & RC_VEC));
      end
   end

   assign cfg_mode  = regq[0];
   assign cfg_pdiv0 = regq[1];
   assign cfg_mpll  = regq[3];
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic              err_pulse,
   input logic              recalc_pulse,
   input logic [31:0]       cfg_mode
);
   logic [ADDR_W-3:0] w;
   logic up_q, is_rc, is_gate, is_map;
   assign w       = req_addr[ADDR_W-1:2];
   assign is_rc   = (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 6);
   assign is_gate = (w == 8) || (w == 9) || (w == 10);
   assign is_map  = is_rc || is_gate || (w == 18) || (w == 23);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up_q <= 1'b0;
      else        up_q <= 1'b1;
   end

   // R8
   p_read_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   p_write_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
   // R7
   p_unmapped_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_map) |=> err_pulse);
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !is_map) |=> (rsp_rdata == 32'h0));
   // R5
   p_const_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && w == 18) |=> (rsp_rdata == 32'h00004040));
   // R9
   p_recalc_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && is_rc) |=> recalc_pulse);
   // R10
   p_no_recalc_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && !(req_valid && req_write && is_rc)) |=> !recalc_pulse);
   // R11
   p_init_recalc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !up_q |=> recalc_pulse);
   // R4
   p_mode_fpm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && w == 0) |=> cfg_mode[2]);
   // R3
   p_mode_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && w == 0) |=> ((cfg_mode & 32'hC4902000) == 32'h0));
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .rsp_valid    (rsp_valid),
   .rsp_rdata    (rsp_rdata),
   .err_pulse    (err_pulse),
   .recalc_pulse (recalc_pulse),
   .cfg_mode     (cfg_mode)
);

// File: tb/test_clkctl_regbank.sv
module test_clkctl_regbank;
   localparam int ADDR_W = 12;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n, req_valid, req_write;
   logic [ADDR_W-1:0] req_addr;
   logic [31:0]       req_wdata, rsp_rdata, cfg_mode, cfg_pdiv0, cfg_mpll;
   logic              rsp_valid, err_pulse, recalc_pulse;

   clkctl_regbank #(.ADDR_W(ADDR_W)) i_clkctl_regbank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .err_pulse(err_pulse), .recalc_pulse(recalc_pulse),
      .cfg_mode(cfg_mode), .cfg_pdiv0(cfg_pdiv0), .cfg_mpll(cfg_mpll)
   );

   int n_tests = 0, n_fail = 0;
   logic [31:0] m [0:31];

   function automatic bit is_mapped(int w);
      return w inside {0, 1, 2, 4, 6, 8, 9, 10, 18, 23};
   endfunction
   function automatic bit is_wr(int w);
      return w inside {0, 1, 2, 4, 6, 8, 9, 10};
   endfunction
   function automatic bit is_rc(int w);
      return w inside {0, 1, 2, 4, 6};
   endfunction
   function automatic logic [31:0] wmask(int w);
      case (w)
         0: return 32'h3B6FDFFF;
         1: return 32'hFF9F3FFF;
         4, 6: return 32'hBFFF3FFF;
         default: return 32'hFFFFFFFF;
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m[i] = 32'h0;
      m[0] = 32'h074B0B7B;  m[1] = 32'hFF870B48;  m[2] = 32'h49FCFE7F;
      m[4] = 32'h04001800;  m[6] = 32'h04043001;
      m[8] = 32'hFFFFFFFF;  m[9] = 32'hFFFFFFFF;  m[10] = 32'hFFFFFFFF;
      m[18] = 32'h00004040; m[23] = 32'h80209828;
   endtask

   // one bus cycle: drive at negedge, check at the following negedge
   task automatic op(bit vld, bit wr, int w, logic [1:0] lo, logic [31:0] d, string tag);
      logic [ADDR_W-3:0] wv;
      bit rd, e_err, e_rc;
      logic [31:0] e_rd;
      wv = w[ADDR_W-3:0];
      req_valid = vld; req_write = wr; req_addr = {wv, lo}; req_wdata = d;
      rd    = vld && !wr;
      e_rd  = (is_mapped(w) && w < 32) ? m[w] : 32'h0;
      e_err = vld && (!is_mapped(w) || (wr && !is_wr(w)));
      e_rc  = vld && wr && is_rc(w);
      if (vld && wr && is_wr(w)) m[w] = (d & wmask(w)) | ((w == 0) ? 32'h4 : 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, rd});
      if (rd) chk(tag, "rsp_rdata", rsp_rdata, e_rd);
      chk(tag, "err_pulse", {31'b0, err_pulse}, {31'b0, e_err});
      chk(tag, "recalc_pulse", {31'b0, recalc_pulse}, {31'b0, e_rc});
      chk(tag, "cfg_mode", cfg_mode, m[0]);
      chk(tag, "cfg_pdiv0", cfg_pdiv0, m[1]);
      chk(tag, "cfg_mpll", cfg_mpll, m[4]);
   endtask

   task automatic read_all(string tag);
      for (int w = 0; w < 32; w++) op(1, 0, w, 2'b00, 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1 R12: reset state on the config outputs and strobes
      chk("R1", "cfg_mode", cfg_mode, 32'h074B0B7B);
      chk("R12", "cfg_pdiv0", cfg_pdiv0, 32'hFF870B48);
      chk("R12", "cfg_mpll", cfg_mpll, 32'h04001800);
      chk("R1", "outs", {29'b0, rsp_valid, err_pulse, recalc_pulse}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "recalc_after_reset", {31'b0, recalc_pulse}, 32'h1);
      op(0, 0, 0, 2'b00, 0, "R11");          // pulse gone next cycle
      read_all("R1");                          // reset values, R5, R7 zeros
      op(1, 0, 1, 2'b11, 0, "R2");             // low address bits ignored
      op(1, 0, 18, 2'b01, 0, "R5");
      foreach (m[i]) if (!is_mapped(i)) op(1, 0, i, 2'b00, 0, "R7");
      op(1, 0, 1023, 2'b00, 0, "R7");
      op(1, 0, 64 + 1, 2'b00, 0, "R7");        // aliasing above word 31
      // R3 R4 mode masking and forced bit
      op(1, 1, 0, 2'b00, 32'hFFFFFFFF, "R3");
      op(1, 0, 0, 2'b00, 0, "R3");
      op(1, 1, 0, 2'b00, 32'h00000000, "R4");
      op(1, 0, 0, 2'b00, 0, "R4");
      // R3 R9 other recompute registers, back to back
      op(1, 1, 1, 2'b00, 32'hFFFFFFFF, "R9");
      op(1, 1, 2, 2'b10, 32'h12345678, "R9");
      op(1, 1, 4, 2'b00, 32'hFFFFFFFF, "R9");
      op(1, 1, 6, 2'b00, 32'hA5A5A5A5, "R9");
      for (int w = 0; w < 7; w++) op(1, 0, w, 2'b00, 0, "R3");
      // R10 gating writes raise no strobe
      op(1, 1, 8, 2'b00, 32'h0000_0001, "R10");
      op(1, 1, 9, 2'b00, 32'h8000_0000, "R10");
      op(1, 1, 10, 2'b00, 32'h0F0F_F0F0, "R10");
      // R6 read-only words
      op(1, 1, 18, 2'b00, 32'hDEADBEEF, "R6");
      op(1, 1, 23, 2'b00, 32'h00000000, "R6");
      op(1, 0, 18, 2'b00, 0, "R6");
      op(1, 0, 23, 2'b00, 0, "R6");
      // R7 unmapped writes change nothing
      op(1, 1, 3, 2'b00, 32'hFFFFFFFF, "R7");
      op(1, 1, 24, 2'b00, 32'h0, "R7");
      op(1, 1, 512, 2'b00, 32'h0, "R7");
      read_all("R7");
      // R8 R9 R10 R12 pseudo-random mix
      lfsr = 32'h1ACE_B00C;
      for (int k = 0; k < 600; k++) begin
         int w;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         w = (lfsr[12:10] == 3'b111) ? int'(lfsr[29:20]) : int'(lfsr[4:0]);
         op(lfsr[7] | lfsr[8], lfsr[9], w, lfsr[6:5], {lfsr[15:0], lfsr[31:16]} ^ lfsr, "R8");
      end
      read_all("R12");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule